// File: doc/BRIEF.md
# Packed SIMD Unsigned Clamp Unit

This block forces every element of a packed data vector into a range given by two other packed vectors of the same width: a lower-bound vector and an upper-bound vector. A 2-bit size code, supplied with each operation, picks how the vector is cut into lanes of 8, 16, 32 or 64 bits. Every lane is treated as an unsigned integer. The data element is first raised to the lower bound if it is below it. The intermediate value is then lowered to the upper bound if it is above it. The packed result replaces the data operand in the caller's storage.

One operation is accepted on any cycle where `valid_in` is high. The result is registered and presented with `valid_out` exactly one clock later. A two-state output controller tracks whether the result register holds fresh data:
- `ST_EMPTY`: no result is presented.
- `ST_FULL`: a result is presented.

Its transitions are named as follows:
- *capture* (ST_EMPTY to ST_FULL) on `valid_in`.
- *refill* (ST_FULL to ST_FULL) on `valid_in`.
- *drain* (ST_FULL to ST_EMPTY) when `valid_in` is low.
- *idle* (ST_EMPTY to ST_EMPTY) when `valid_in` is low.

The unsigned compare is built once per byte. The per-byte flags are chained inside each lane according to the size code, so all four lane widths share one datapath.

Top module: `vclamp_unit`

## Requirements
- R1: Size code 0, 1, 2 and 3 selects lanes of 8, 16, 32 and 64 bits respectively. The vector holds VEC_W divided by that width lanes, and lane 0 occupies the least significant bits.
- R2: Each lane's result equals min(max(data, lower), upper) computed on that lane's elements.
- R3: When a lane's lower bound is greater than its upper bound, that lane's result equals the upper bound.
- R4: All compares are unsigned. An element with its top bit set is larger than any element with its top bit clear (for example, byte 0x80 is greater than byte 0x7F).
- R5: Each lane's result depends only on the bits of that lane. No compare result or value crosses a lane boundary, and results are exactly the element width.
- R6: Every lane is written on every accepted operation. There is no mask, so a new operation replaces every lane of the previous result.
- R7: When `valid_in` is high at a clock edge, `valid_out` is high and `result_out` holds that operation's result after the edge.
- R8: When `valid_in` is low at a clock edge, `valid_out` is low after the edge and `result_out` keeps its previous value.
- R9: A synchronous active-high `rst` clears `valid_out` and `result_out` to zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operation accepted this cycle |
| size_in | input | 2 | Lane size code: 0=8, 1=16, 2=32, 3=64 bits |
| lo_in | input | VEC_W | Packed lower-bound elements |
| hi_in | input | VEC_W | Packed upper-bound elements |
| data_in | input | VEC_W | Packed data elements to be clamped |
| valid_out | output | 1 | Result register holds a fresh result |
| result_out | output | VEC_W | Packed clamped elements |

## Verification
Two functions can fall in the same cycle:
- The raise-to-lower and lower-to-upper steps can both fire in one lane. This happens when the bounds are inverted and the data lies below the lower bound.
- A *refill* can overwrite a presented result while `valid_out` stays high.

The bench provokes the first with directed lanes whose lower bound exceeds the upper bound. It provokes the second with random back-to-back operations whose size code changes from one cycle to the next. Both are judged against a behavioural per-lane model that is compared on every clock.

// File: rtl/vclamp_pkg.sv
`timescale 1ns/1ps
package vclamp_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_B16 = 2'd1,
        SZ_B32 = 2'd2,
        SZ_B64 = 2'd3
    } lane_sz_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_st_e;

    // Byte-offset mask inside a lane: bytes per lane minus one.
    function automatic logic [2:0] lane_mask(input lane_sz_e s);
        logic [2:0] m;
        unique case (s)
            SZ_B8:   m = 3'd0;
            SZ_B16:  m = 3'd1;
            SZ_B32:  m = 3'd3;
            SZ_B64:  m = 3'd7;
            default: m = 3'd0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vclamp_byte_cmp.sv
`timescale 1ns/1ps
module vclamp_byte_cmp
    import vclamp_pkg::*;
(
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] b,
    output logic              gt,
    output logic              eq
);

    assign gt = (a > b);
    assign eq = (a == b);

endmodule

// File: rtl/vclamp_lane_gt.sv
`timescale 1ns/1ps
// Unsigned a > b per lane, with the lane width chosen at run time.
// Byte flags are chained from each lane's low byte to its high byte.
// The lane's flag is then copied to every byte of that lane.
module vclamp_lane_gt
    import vclamp_pkg::*;
#(
    parameter int unsigned NB = 32
) (
    input  lane_sz_e             size,
    input  logic [NB*BYTE_W-1:0] a,
    input  logic [NB*BYTE_W-1:0] b,
    output logic [NB-1:0]        gt
);

    localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1;

    logic [NB-1:0] byte_gt;
    logic [NB-1:0] byte_eq;
    logic [NB-1:0] chain;

    generate
        for (genvar i = 0; i < NB; i++) begin : g_byte
            vclamp_byte_cmp u_cmp (
                .a  (a[i*BYTE_W +: BYTE_W]),
                .b  (b[i*BYTE_W +: BYTE_W]),
                .gt (byte_gt[i]),
                .eq (byte_eq[i])
            );
        end
    endgenerate

    // Ripple from low byte to high byte, restarting at each lane base.
    always_comb begin
        logic [2:0] lm;
        logic       prev;
        logic       base;
        lm    = lane_mask(size);
        prev  = 1'b0;
        chain = '0;
        for (int i = 0; i < NB; i++) begin
            base     = ((3'(i) & lm) == 3'd0);
            chain[i] = byte_gt[i] | (byte_eq[i] & prev & ~base);
            prev     = chain[i];
        end
    end

    // The verdict sits in the lane's top byte; copy it lane-wide.
    always_comb begin
        logic [IW-1:0] top;
        for (int i = 0; i < NB; i++) begin
            top   = IW'(i) | IW'(lane_mask(size));
            gt[i] = chain[top];
        end
    end

endmodule

// File: rtl/vclamp_ctrl.sv
`timescale 1ns/1ps
module vclamp_ctrl
    import vclamp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic valid_in,
    output logic load,
    output logic valid_out
);

    out_st_e st_q;
    out_st_e st_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: if (valid_in)  st_d = ST_FULL;   // capture
            ST_FULL:  if (!valid_in) st_d = ST_EMPTY;  // drain (refill stays)
            default:  st_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        load      = valid_in;
        valid_out = (st_q == ST_FULL);
    end

endmodule

// File: rtl/vclamp_unit.sv
`timescale 1ns/1ps
module vclamp_unit
    import vclamp_pkg::*;
#(
    parameter int unsigned VEC_W = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_in,
    input  logic [1:0]       size_in,
    input  logic [VEC_W-1:0] lo_in,
    input  logic [VEC_W-1:0] hi_in,
    input  logic [VEC_W-1:0] data_in,
    output logic             valid_out,
    output logic [VEC_W-1:0] result_out
);

    localparam int unsigned NB = VEC_W / BYTE_W;

    generate
        if ((VEC_W % 64) != 0 || VEC_W == 0) begin : g_bad_width
            $error("VEC_W must be a non-zero multiple of 64");
        end
    endgenerate

    lane_sz_e         sz;
    logic [NB-1:0]    data_above_lo;
    logic [NB-1:0]    raised_above_hi;
    logic [VEC_W-1:0] raised;
    logic [VEC_W-1:0] clamped;
    logic [VEC_W-1:0] res_q;
    logic             load;

    assign sz = lane_sz_e'(size_in);

    // Step one: raise to the lower bound.
    vclamp_lane_gt #(.NB(NB)) u_lo_cmp (
        .size (sz),
        .a    (data_in),
        .b    (lo_in),
        .gt   (data_above_lo)
    );

    // Step two: lower to the upper bound (decides inverted bounds).
    vclamp_lane_gt #(.NB(NB)) u_hi_cmp (
        .size (sz),
        .a    (raised),
        .b    (hi_in),
        .gt   (raised_above_hi)
    );

    generate
        for (genvar i = 0; i < NB; i++) begin : g_mux
            assign raised[i*BYTE_W +: BYTE_W]  = data_above_lo[i]
                                               ? data_in[i*BYTE_W +: BYTE_W]
                                               : lo_in[i*BYTE_W +: BYTE_W];
            assign clamped[i*BYTE_W +: BYTE_W] = raised_above_hi[i]
                                               ? hi_in[i*BYTE_W +: BYTE_W]
                                               : raised[i*BYTE_W +: BYTE_W];
        end
    endgenerate

    vclamp_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_in),
        .load      (load),
        .valid_out (valid_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (load) begin
            res_q <= clamped;
        end
    end

    assign result_out = res_q;

endmodule

// File: rtl/vclamp_chk.sv
`timescale 1ns/1ps
module vclamp_chk #(
    parameter int unsigned VEC_W = 256
) (
    input logic             clk,
    input logic             rst,
    input logic             valid_in,
    input logic [1:0]       size_in,
    input logic [VEC_W-1:0] lo_in,
    input logic [VEC_W-1:0] hi_in,
    input logic [VEC_W-1:0] data_in,
    input logic             valid_out,
    input logic [VEC_W-1:0] result_out
);

    // R9
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!valid_out && result_out == '0));

    // R7
    issue_latency_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> (!valid_out && $stable(result_out)));

    // R3
    inverted_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && size_in == 2'd0 && lo_in[7:0] > hi_in[7:0])
        |=> result_out[7:0] == $past(hi_in[7:0]));

    // R2
    in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && size_in == 2'd3 && lo_in[63:0] <= hi_in[63:0])
        |=> (result_out[63:0] >= $past(lo_in[63:0]) &&
             result_out[63:0] <= $past(hi_in[63:0])));

endmodule

bind vclamp_unit vclamp_chk #(.VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .valid_in   (valid_in),
    .size_in    (size_in),
    .lo_in      (lo_in),
    .hi_in      (hi_in),
    .data_in    (data_in),
    .valid_out  (valid_out),
    .result_out (result_out)
);

// File: tb/sim_vclamp_unit.sv
`timescale 1ns/1ps
module sim_vclamp_unit;

    localparam int unsigned VEC_W = 256;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             valid_in = 1'b0;
    logic [1:0]       size_in = 2'd0;
    logic [VEC_W-1:0] lo_in = '0;
    logic [VEC_W-1:0] hi_in = '0;
    logic [VEC_W-1:0] data_in = '0;
    logic             valid_out;
    logic [VEC_W-1:0] result_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit live   = 1'b0;

    logic             m_valid = 1'b0;
    logic [VEC_W-1:0] m_res = '0;

    always #2.5 clk = ~clk;

    vclamp_unit #(.VEC_W(VEC_W)) u0 (
        .clk        (clk),
        .rst        (rst),
        .valid_in   (valid_in),
        .size_in    (size_in),
        .lo_in      (lo_in),
        .hi_in      (hi_in),
        .data_in    (data_in),
        .valid_out  (valid_out),
        .result_out (result_out)
    );

    function automatic logic [VEC_W-1:0] ref_clamp(input logic [1:0] sz,
            input logic [VEC_W-1:0] lo, input logic [VEC_W-1:0] hi,
            input logic [VEC_W-1:0] d);
        int ew = 8 << sz;
        int nl = VEC_W / ew;
        longint unsigned mk = (ew == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ew) - 64'd1);
        logic [VEC_W-1:0] r = '0;
        for (int e = 0; e < nl; e++) begin
            longint unsigned a = 64'(d  >> (e * ew)) & mk;
            longint unsigned l = 64'(lo >> (e * ew)) & mk;
            longint unsigned h = 64'(hi >> (e * ew)) & mk;
            longint unsigned x = (a > l) ? a : l;
            if (x > h) x = h;
            r = r | (VEC_W'(x) << (e * ew));
        end
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] rnd_vec();
        logic [VEC_W-1:0] r;
        for (int k = 0; k < VEC_W / 32; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic chk(input bit ok, input string what,
                       input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // Behavioural reference: one register stage, updated on accept.
    always @(posedge clk) begin
        if (rst) begin
            m_valid <= 1'b0;
            m_res   <= '0;
        end else begin
            m_valid <= valid_in;
            if (valid_in) m_res <= ref_clamp(size_in, lo_in, hi_in, data_in);
        end
    end

    always @(negedge clk) begin
        if (live) begin
            chk(valid_out == m_valid, "R7/R8 valid_out",
                VEC_W'(valid_out), VEC_W'(m_valid));
            chk(result_out == m_res, "R2 per-cycle result", result_out, m_res);
        end
    end

    task automatic op(input logic [1:0] sz, input logic [VEC_W-1:0] lo,
                      input logic [VEC_W-1:0] hi, input logic [VEC_W-1:0] d,
                      input logic [VEC_W-1:0] exp, input string tag);
        @(posedge clk); #1;
        size_in = sz; lo_in = lo; hi_in = hi; data_in = d; valid_in = 1'b1;
        @(posedge clk); #1;
        valid_in = 1'b0;
        @(negedge clk);
        chk(result_out == exp, tag, result_out, exp);
        @(negedge clk);
        chk(result_out == exp, "R8 result held while idle", result_out, exp);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R7 act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        logic [VEC_W-1:0] d;
        logic [VEC_W-1:0] lo_v;
        logic [VEC_W-1:0] hi_v;
        repeat (3) @(negedge clk);
        chk(!valid_out && result_out == '0, "R9 reset state", result_out, '0);
        @(posedge clk); #1;
        rst = 1'b0;
        live = 1'b1;

        // R1: each size code on the same operands
        lo_v = {32{8'h30}};
        hi_v = {32{8'hA0}};
        for (int s = 0; s < 4; s++) begin
            d = rnd_vec();
            op(2'(s), lo_v, hi_v, d, ref_clamp(2'(s), lo_v, hi_v, d), "R1 size code lane split");
        end
        // R1: lane 0 at LSB, 16-bit lanes, hand-computed values
        d = '0; d[15:0] = 16'h0005; d[31:16] = 16'hFFFF;
        lo_v = '0; lo_v[15:0] = 16'h0100;
        hi_v = {16{16'h8000}};
        op(2'd1, lo_v, hi_v, d,
           {{(VEC_W-32){1'b0}}, 16'h8000, 16'h0100} | ref_clamp(2'd1, lo_v, hi_v, d),
           "R1 lane 0 at least significant bits");

        // R3: inverted bounds give upper bound
        lo_v = {32{8'hF0}};
        hi_v = {32{8'h10}};
        op(2'd0, lo_v, hi_v, rnd_vec(), hi_v, "R3 inverted bounds 8-bit");
        lo_v = {4{64'h9000_0000_0000_0000}};
        hi_v = {4{64'h0000_0000_0000_1234}};
        op(2'd3, lo_v, hi_v, rnd_vec(), hi_v, "R3 inverted bounds 64-bit");

        // R4: unsigned compare
        op(2'd0, {32{8'h7F}}, {32{8'hFF}}, {32{8'h80}}, {32{8'h80}}, "R4 unsigned 0x80 above 0x7F");
        op(2'd2, {8{32'h0000_0001}}, {8{32'hFFFF_FFFE}}, {8{32'hFFFF_FFFF}},
           {8{32'hFFFF_FFFE}}, "R4 unsigned top-bit data clipped to upper");

        // R5: no influence across lanes
        op(2'd3, '0, {4{64'h00FF_FFFF_FFFF_FFFF}}, {4{64'h0100_0000_0000_0000}},
           {4{64'h00FF_FFFF_FFFF_FFFF}}, "R5 high byte decides 64-bit lane");
        op(2'd0, '0, {32{8'h01}}, {32{8'hFF}}, {32{8'h01}}, "R5 byte lanes isolated");
        op(2'd1, {16{16'h00FF}}, {16{16'h0100}}, {16{16'h01FE}}, {16{16'h0100}},
           "R5 16-bit lane compares both bytes");

        // R6: every lane rewritten
        op(2'd2, '0, '0, rnd_vec(), '0, "R6 all lanes replaced");

        // R2/R7/R8: random traffic, back-to-back with size changes
        for (int c = 0; c < 600; c++) begin
            @(posedge clk); #1;
            valid_in = ($urandom % 4) != 0;
            size_in  = 2'($urandom);
            lo_in    = rnd_vec();
            hi_in    = rnd_vec();
            data_in  = rnd_vec();
            if ((c % 3) == 0) begin
                for (int b = 0; b < VEC_W / 8; b++) begin
                    lo_in[b*8 +: 8] = lo_in[b*8 +: 8] >> 1;
                    hi_in[b*8 +: 8] = hi_in[b*8 +: 8] | 8'h80;
                end
            end
        end
        @(posedge clk); #1;
        valid_in = 1'b0;
        @(negedge clk);

        // R9: reset in the middle of traffic
        @(posedge clk); #1;
        valid_in = 1'b1; size_in = 2'd0;
        lo_in = {32{8'h20}}; hi_in = {32{8'hE0}}; data_in = rnd_vec();
        @(posedge clk); #1;
        valid_in = 1'b0; rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!valid_out && result_out == '0, "R9 synchronous reset clears", result_out, '0);
        @(posedge clk); #1;
        rst = 1'b0;
        repeat (2) @(negedge clk);

        live = 1'b0;
        summary();
        $finish;
    end

endmodule